// File: doc/BRIEF.md
# IPC Inbound Message Dispatcher

This block services the host side of a doorbell pair that a DSP uses to talk back to its host. An interrupt event starts a fixed handling sequence. If the DSP has signalled that it consumed the last outbound message (the outbound done flag), the block masks the done interrupt enable, pulses a write-one clear of the done flag, and then restores the enable. If the DSP has posted a new inbound message (the inbound busy flag), the block captures the 32-bit primary and extension words and sorts the message. A reply to an outstanding request is completed with a decoded error code. A notification is turned into one of four event strobes. The block then pulses a write-one clear of busy.

The host posts one outstanding request at a time with a tag. The block holds that tag in a one-entry slot, returns it with the completion, and frees the slot. When at least one flag was serviced, the block ends the sequence with a pulse that re-enables the IPC interrupt and a pulse that asks the transmitter to send its next queued message. An event that finds neither flag set is reported as not handled.

Top module: `ipc_rx_dispatch`

## Requirements
- R1: Primary bit 29 set marks a reply and bit 29 clear marks a notification. A notification never produces a completion and leaves the pending slot occupied.
- R2: The reply status is primary bits 23:0. It maps onto `cmpl_err` as follows: 0 gives 0 (success), 3 gives 1 (busy), 7 gives 2 (out of memory), and every other value gives 3 (invalid).
- R3: A notification is acted on only when primary bits 28:24 are nonzero. Bits 23:16 then select exactly one strobe: 2 gives `ev_underrun`, 5 gives `ev_budget`, 8 gives `ev_ready`, and any other value gives `ev_unhandled`. When bits 28:24 are zero, no strobe fires.
- R4: Servicing done takes two cycles with `done_ie` low. `done_clr` pulses in the second of them, and `done_ie` is high again in the cycle after.
- R5: Servicing busy captures both words in one cycle and dispatches in the next cycle, when the completion or event is visible. `busy_clr` pulses in the cycle after dispatch. `cmpl_ext` returns the captured extension word.
- R6: A reply that arrives while the pending slot is empty produces no completion. The busy clear and the ending pulses still occur.
- R7: When done or busy was serviced, `ie_set` and `tx_kick` pulse together for one cycle right after the last clear pulse. When neither was set at the event, only `irq_none` pulses, one cycle after the event.
- R8: When both flags are set at the event, the whole done sequence completes before the busy capture starts.
- R9: `cmpl_valid`, with `cmpl_err`, `cmpl_tag` and `cmpl_ext`, lasts exactly one cycle. `cmpl_tag` equals the posted tag, and the pending slot is empty from the next cycle on.
- R10: The slot holds one request. `req_post` while `pend_full` is high is ignored, and the earlier tag is the one that is completed.
- R11: `irq_ev` is ignored while a handling sequence is in progress.
- R12: After reset, `done_ie` is high, `pend_full` is low and every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_ev | input | 1 | Interrupt event; starts a handling sequence when the block is idle |
| in_primary | input | 32 | Inbound primary word |
| in_ext | input | 32 | Inbound extension word |
| in_busy | input | 1 | Inbound message present flag |
| out_done | input | 1 | Outbound message consumed flag |
| req_post | input | 1 | Post a request into the pending slot |
| req_tag | input | 4 | Tag of the posted request |
| pend_full | output | 1 | Pending slot occupied |
| done_ie | output | 1 | Done interrupt enable |
| done_clr | output | 1 | Write-one clear of the done flag |
| busy_clr | output | 1 | Write-one clear of the busy flag |
| ie_set | output | 1 | Re-enable the IPC interrupt |
| tx_kick | output | 1 | Ask the transmitter for the next message |
| irq_none | output | 1 | Event was not handled |
| cmpl_valid | output | 1 | Completion strobe |
| cmpl_err | output | 2 | Completion error code |
| cmpl_tag | output | 4 | Tag of the completed request |
| cmpl_ext | output | 32 | Extension word of the reply |
| ev_underrun | output | 1 | Underrun notification strobe |
| ev_budget | output | 1 | Resource budget notification strobe |
| ev_ready | output | 1 | Firmware ready notification strobe |
| ev_unhandled | output | 1 | Other notification strobe |

## Verification
The assertions take for granted that the two flags and both message words stay steady from the event until the ending pulse. They also assume the flags drop only after the matching clear has been given. The stimulus holds the words and flags for eight cycles after each event and releases them only after the sequence has finished. A second event is raised on purpose only inside a running sequence, to exercise R11.

// File: rtl/ipc_rx_pkg.sv
package ipc_rx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_DMASK = 3'd1,
      ST_DCLR  = 3'd2,
      ST_BCAP  = 3'd3,
      ST_BDISP = 3'd4,
      ST_BCLR  = 3'd5,
      ST_FIN   = 3'd6,
      ST_NONE  = 3'd7
   } seq_st_t;

   typedef enum logic [1:0] {
      ERR_OK    = 2'd0,
      ERR_BUSY  = 2'd1,
      ERR_NOMEM = 2'd2,
      ERR_INVAL = 2'd3
   } cmpl_err_t;

   localparam int EV_N     = 4;
   localparam int EV_UNDER = 0;
   localparam int EV_BUDG  = 1;
   localparam int EV_READY = 2;
   localparam int EV_OTHER = 3;

endpackage

// File: rtl/ipc_rx_seq.sv
module ipc_rx_seq
   import ipc_rx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic irq_ev,
   input  logic out_done,
   input  logic in_busy,
   output logic done_ie,
   output logic done_clr,
   output logic cap_en,
   output logic disp_en,
   output logic busy_clr,
   output logic ie_set,
   output logic tx_kick,
   output logic irq_none
);

   seq_st_t st_q, st_d;
   logic    busy_q, busy_d;

   always_comb begin
      st_d   = st_q;
      busy_d = busy_q;
      case (st_q)
         ST_IDLE: begin
            if (irq_ev) begin
               busy_d = in_busy;
               if (out_done)     st_d = ST_DMASK;
               else if (in_busy) st_d = ST_BCAP;
               else              st_d = ST_NONE;
            end
         end
         ST_DMASK: st_d = ST_DCLR;
         ST_DCLR:  st_d = busy_q ? ST_BCAP : ST_FIN;
         ST_BCAP:  st_d = ST_BDISP;
         ST_BDISP: st_d = ST_BCLR;
         ST_BCLR:  st_d = ST_FIN;
         ST_FIN:   st_d = ST_IDLE;
         ST_NONE:  st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         busy_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         busy_q <= busy_d;
      end
   end

   assign done_ie  = !(st_q == ST_DMASK || st_q == ST_DCLR);
   assign done_clr = (st_q == ST_DCLR);
   assign cap_en   = (st_q == ST_BCAP);
   assign disp_en  = (st_q == ST_BDISP);
   assign busy_clr = (st_q == ST_BCLR);
   assign ie_set   = (st_q == ST_FIN);
   assign tx_kick  = (st_q == ST_FIN);
   assign irq_none = (st_q == ST_NONE);

   // R4
   mask_before_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_clr |-> $past(!done_ie));
   // R4
   unmask_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_clr |=> done_ie);
   // R7
   kick_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_kick |-> $past(done_clr || busy_clr));
   // R7
   none_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_none |-> $past(irq_ev && !out_done && !in_busy));
   // R8
   done_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && $past(done_ie)) |-> $past(irq_ev && !out_done));

endmodule

// File: rtl/ipc_rx_pend.sv
module ipc_rx_pend #(
   parameter int TAG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             post,
   input  logic [TAG_W-1:0] post_tag,
   input  logic             take,
   output logic             full,
   output logic [TAG_W-1:0] tag
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         tag  <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (post && !full) begin
         full <= 1'b1;
         tag  <= post_tag;
      end
   end

   // R10
   post_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (post && full && !take) |=> (full && $stable(tag)));

endmodule

// File: rtl/ipc_rx_decode.sv
module ipc_rx_decode
   import ipc_rx_pkg::*;
#(
   parameter int WORD_W        = 32,
   parameter int TAG_W         = 4,
   parameter int DIR_BIT       = 29,
   parameter int STAT_W        = 24,
   parameter int MTYPE_LSB     = 24,
   parameter int MTYPE_W       = 5,
   parameter int NTYPE_LSB     = 16,
   parameter int NTYPE_W       = 8,
   parameter int OK_CODE       = 0,
   parameter int BUSY_CODE     = 3,
   parameter int NOMEM_CODE    = 7,
   parameter int UNDER_CODE    = 2,
   parameter int BUDG_CODE     = 5,
   parameter int READY_CODE    = 8,
   parameter bit CAPTURE_EXT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              disp_en,
   input  logic [WORD_W-1:0] in_primary,
   input  logic [WORD_W-1:0] in_ext,
   input  logic              pend_full,
   input  logic [TAG_W-1:0]  pend_tag,
   output logic              cmpl_valid,
   output logic [1:0]        cmpl_err,
   output logic [TAG_W-1:0]  cmpl_tag,
   output logic [WORD_W-1:0] cmpl_ext,
   output logic [EV_N-1:0]   ev,
   output logic              take
);

   localparam int N_CODED = EV_N - 1;
   localparam logic [N_CODED*NTYPE_W-1:0] CODES =
      {NTYPE_W'(READY_CODE), NTYPE_W'(BUDG_CODE), NTYPE_W'(UNDER_CODE)};

   logic [WORD_W-1:0]  prim_q;
   logic               is_reply;
   logic [STAT_W-1:0]  status;
   logic [MTYPE_W-1:0] mtype;
   logic [NTYPE_W-1:0] ntype;
   logic               notif;
   logic [N_CODED-1:0] hit;
   cmpl_err_t          err_c;
   logic               unused_prim;

   always_ff @(posedge clk) begin
      if (!rst_n)      prim_q <= '0;
      else if (cap_en) prim_q <= in_primary;
   end

   generate
      if (CAPTURE_EXT) begin : g_ext
         logic [WORD_W-1:0] ext_q;
         always_ff @(posedge clk) begin
            if (!rst_n)      ext_q <= '0;
            else if (cap_en) ext_q <= in_ext;
         end
         assign cmpl_ext = ext_q;
      end else begin : g_no_ext
         logic unused_ext;
         assign unused_ext = ^in_ext;
         assign cmpl_ext   = '0;
      end
   endgenerate

   assign unused_prim = ^prim_q;
   assign is_reply    = prim_q[DIR_BIT];
   assign status      = prim_q[STAT_W-1:0];
   assign mtype       = prim_q[MTYPE_LSB +: MTYPE_W];
   assign ntype       = prim_q[NTYPE_LSB +: NTYPE_W];

   always_comb begin
      if (status == STAT_W'(OK_CODE))         err_c = ERR_OK;
      else if (status == STAT_W'(BUSY_CODE))  err_c = ERR_BUSY;
      else if (status == STAT_W'(NOMEM_CODE)) err_c = ERR_NOMEM;
      else                                    err_c = ERR_INVAL;
   end

   assign cmpl_valid = disp_en && is_reply && pend_full;
   assign take       = cmpl_valid;
   assign cmpl_err   = err_c;
   assign cmpl_tag   = pend_tag;

   assign notif = disp_en && !is_reply && (mtype != '0);

   generate
      for (genvar i = 0; i < N_CODED; i++) begin : g_ev
         assign hit[i] = (ntype == CODES[i*NTYPE_W +: NTYPE_W]);
         assign ev[i]  = notif && hit[i];
      end
   endgenerate
   assign ev[EV_OTHER] = notif && !(|hit);

   // R3
   one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ev));
   // R5
   disp_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ev) || cmpl_valid) |-> $past(cap_en));
   // R1
   no_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmpl_valid && (|ev)));

endmodule

// File: rtl/ipc_rx_dispatch.sv
module ipc_rx_dispatch
   import ipc_rx_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int TAG_W       = 4,
   parameter int DIR_BIT     = 29,
   parameter int STAT_W      = 24,
   parameter int MTYPE_LSB   = 24,
   parameter int MTYPE_W     = 5,
   parameter int NTYPE_LSB   = 16,
   parameter int NTYPE_W     = 8,
   parameter bit CAPTURE_EXT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_ev,
   input  logic [WORD_W-1:0] in_primary,
   input  logic [WORD_W-1:0] in_ext,
   input  logic              in_busy,
   input  logic              out_done,
   input  logic              req_post,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              pend_full,
   output logic              done_ie,
   output logic              done_clr,
   output logic              busy_clr,
   output logic              ie_set,
   output logic              tx_kick,
   output logic              irq_none,
   output logic              cmpl_valid,
   output logic [1:0]        cmpl_err,
   output logic [TAG_W-1:0]  cmpl_tag,
   output logic [WORD_W-1:0] cmpl_ext,
   output logic              ev_underrun,
   output logic              ev_budget,
   output logic              ev_ready,
   output logic              ev_unhandled
);

   initial begin
      assert (DIR_BIT < WORD_W) else $error("direction bit outside word");
      assert (STAT_W <= WORD_W && STAT_W > 0) else $error("status width");
      assert (MTYPE_LSB + MTYPE_W <= WORD_W) else $error("message type field");
      assert (NTYPE_LSB + NTYPE_W <= WORD_W) else $error("notification field");
      assert (TAG_W > 0) else $error("tag width");
   end

   logic            cap_en, disp_en, take;
   logic [TAG_W-1:0] pend_tag;
   logic [EV_N-1:0] ev;

   ipc_rx_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_ev   (irq_ev),
      .out_done (out_done),
      .in_busy  (in_busy),
      .done_ie  (done_ie),
      .done_clr (done_clr),
      .cap_en   (cap_en),
      .disp_en  (disp_en),
      .busy_clr (busy_clr),
      .ie_set   (ie_set),
      .tx_kick  (tx_kick),
      .irq_none (irq_none)
   );

   ipc_rx_pend #(.TAG_W(TAG_W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .post     (req_post),
      .post_tag (req_tag),
      .take     (take),
      .full     (pend_full),
      .tag      (pend_tag)
   );

   ipc_rx_decode #(
      .WORD_W      (WORD_W),
      .TAG_W       (TAG_W),
      .DIR_BIT     (DIR_BIT),
      .STAT_W      (STAT_W),
      .MTYPE_LSB   (MTYPE_LSB),
      .MTYPE_W     (MTYPE_W),
      .NTYPE_LSB   (NTYPE_LSB),
      .NTYPE_W     (NTYPE_W),
      .CAPTURE_EXT (CAPTURE_EXT)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_en     (cap_en),
      .disp_en    (disp_en),
      .in_primary (in_primary),
      .in_ext     (in_ext),
      .pend_full  (pend_full),
      .pend_tag   (pend_tag),
      .cmpl_valid (cmpl_valid),
      .cmpl_err   (cmpl_err),
      .cmpl_tag   (cmpl_tag),
      .cmpl_ext   (cmpl_ext),
      .ev         (ev),
      .take       (take)
   );

   assign ev_underrun  = ev[EV_UNDER];
   assign ev_budget    = ev[EV_BUDG];
   assign ev_ready     = ev[EV_READY];
   assign ev_unhandled = ev[EV_OTHER];

   // R9
   slot_free_after_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_valid |=> (!pend_full && !cmpl_valid));
   // R6
   cmpl_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmpl_valid |-> $past(pend_full));

endmodule

// File: tb/ipc_rx_dispatch_test.sv
module ipc_rx_dispatch_test;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG       = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_ev = 1'b0;
   logic [31:0] in_primary = '0;
   logic [31:0] in_ext = '0;
   logic        in_busy = 1'b0;
   logic        out_done = 1'b0;
   logic        req_post = 1'b0;
   logic [3:0]  req_tag = '0;
   logic        pend_full, done_ie, done_clr, busy_clr, ie_set, tx_kick, irq_none;
   logic        cmpl_valid;
   logic [1:0]  cmpl_err;
   logic [3:0]  cmpl_tag;
   logic [31:0] cmpl_ext;
   logic        ev_underrun, ev_budget, ev_ready, ev_unhandled;

   int checks = 0;
   int errors = 0;

   logic [48:0] exp_q[$];
   string       req_q[$];

   bit          m_pend = 1'b0;
   logic [3:0]  m_tag  = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipc_rx_dispatch uut (
      .clk(clk), .rst_n(rst_n), .irq_ev(irq_ev), .in_primary(in_primary),
      .in_ext(in_ext), .in_busy(in_busy), .out_done(out_done),
      .req_post(req_post), .req_tag(req_tag), .pend_full(pend_full),
      .done_ie(done_ie), .done_clr(done_clr), .busy_clr(busy_clr),
      .ie_set(ie_set), .tx_kick(tx_kick), .irq_none(irq_none),
      .cmpl_valid(cmpl_valid), .cmpl_err(cmpl_err), .cmpl_tag(cmpl_tag),
      .cmpl_ext(cmpl_ext), .ev_underrun(ev_underrun), .ev_budget(ev_budget),
      .ev_ready(ev_ready), .ev_unhandled(ev_unhandled)
   );

   function automatic logic [48:0] mk(input logic [31:0] ext, input logic cv,
      input logic [1:0] er, input logic [3:0] tg, input logic [3:0] ev,
      input logic mask, input logic dclr, input logic bclr, input logic fin,
      input logic none);
      return {ext, cv, er, tg, ev, mask, dclr, bclr, fin, fin, none};
   endfunction

   task automatic check(input string req, input logic [48:0] act, input logic [48:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: compares every visible output cycle against the expected queue
   always @(negedge clk) begin
      logic [48:0] obs;
      if (rst_n) begin
         obs = mk(cmpl_valid ? cmpl_ext : 32'h0, cmpl_valid,
                  cmpl_valid ? cmpl_err : 2'd0, cmpl_valid ? cmpl_tag : 4'd0,
                  {ev_underrun, ev_budget, ev_ready, ev_unhandled},
                  !done_ie, done_clr, busy_clr, ie_set && tx_kick, irq_none);
         if (ie_set !== tx_kick) check("R7 ie_set/tx_kick pair", {48'd0, ie_set}, {48'd0, tx_kick});
         if (obs != '0) begin
            if (exp_q.size() == 0) check("unexpected output", obs, '0);
            else check(req_q.pop_front(), obs, exp_q.pop_front());
         end
      end
   end

   function automatic logic [1:0] err_of(input logic [23:0] st);
      if (st == 24'd0) return 2'd0;
      if (st == 24'd3) return 2'd1;
      if (st == 24'd7) return 2'd2;
      return 2'd3;
   endfunction

   task automatic push(input logic [48:0] e, input string r);
      exp_q.push_back(e);
      req_q.push_back(r);
   endtask

   task automatic expect_txn(input bit dn, input bit bs, input logic [31:0] p, input logic [31:0] x);
      if (dn) begin
         push(mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 0), "R4 mask cycle");
         push(mk(0, 0, 0, 0, 0, 1, 1, 0, 0, 0), "R4 clear under mask");
      end
      if (bs) begin
         if (p[29]) begin
            if (m_pend) begin
               push(mk(x, 1, err_of(p[23:0]), m_tag, 0, 0, 0, 0, 0, 0), "R2 R5 R9 completion");
               m_pend = 1'b0;
            end
         end else if (p[28:24] != 0) begin
            case (p[23:16])
               8'd2:    push(mk(0, 0, 0, 0, 4'b1000, 0, 0, 0, 0, 0), "R3 underrun");
               8'd5:    push(mk(0, 0, 0, 0, 4'b0100, 0, 0, 0, 0, 0), "R3 budget");
               8'd8:    push(mk(0, 0, 0, 0, 4'b0010, 0, 0, 0, 0, 0), "R3 ready");
               default: push(mk(0, 0, 0, 0, 4'b0001, 0, 0, 0, 0, 0), "R3 unhandled");
            endcase
         end
         push(mk(0, 0, 0, 0, 0, 0, 0, 1, 0, 0), "R5 busy clear");
      end
      if (dn || bs) push(mk(0, 0, 0, 0, 0, 0, 0, 0, 1, 0), "R7 R8 reenable and kick");
      else          push(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 1), "R7 not handled");
   endtask

   task automatic fire(input bit dn, input bit bs, input logic [31:0] p, input logic [31:0] x);
      @(posedge clk); #1;
      in_primary = p; in_ext = x; in_busy = bs; out_done = dn; irq_ev = 1'b1;
      @(posedge clk); #1;
      irq_ev = 1'b0;
      repeat (8) @(posedge clk);
      #1;
      in_busy = 1'b0; out_done = 1'b0;
      repeat (2) @(posedge clk);
   endtask

   task automatic txn(input bit dn, input bit bs, input logic [31:0] p, input logic [31:0] x);
      expect_txn(dn, bs, p, x);
      fire(dn, bs, p, x);
   endtask

   task automatic post(input logic [3:0] t);
      @(posedge clk); #1;
      req_post = 1'b1; req_tag = t;
      if (!m_pend) begin m_pend = 1'b1; m_tag = t; end
      @(posedge clk); #1;
      req_post = 1'b0;
   endtask

   task automatic check_pend(input string r);
      check(r, {48'd0, pend_full}, {48'd0, m_pend});
   endtask

   function automatic logic [31:0] reply(input logic [23:0] st);
      return (32'h1 << 29) | {8'h0, st};
   endfunction

   function automatic logic [31:0] notify(input logic [4:0] mt, input logic [7:0] nt);
      return {3'b000, mt, nt, 16'h0};
   endfunction

   initial begin
      repeat (WDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R12 reset state
      check("R12 reset outputs",
            {41'd0, done_ie, pend_full, done_clr, busy_clr, ie_set, tx_kick, irq_none, cmpl_valid},
            {41'd0, 1'b1, 7'd0});
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check("R12 idle after reset",
            {44'd0, done_ie, ev_underrun, ev_budget, ev_ready, ev_unhandled},
            {44'd0, 1'b1, 4'd0});

      post(4'd5);
      check_pend("R10 slot filled");
      txn(0, 1, reply(24'd0), 32'hCAFE_0001);
      check_pend("R9 slot freed");

      post(4'd9);
      post(4'd3);
      check_pend("R10 second post ignored");
      txn(0, 1, reply(24'd7), 32'h1234_5678);

      post(4'd2);
      txn(1, 1, reply(24'd3), 32'hA5A5_0F0F);

      post(4'd12);
      txn(0, 1, notify(5'd1, 8'd8), 32'h0);
      check_pend("R1 notification keeps slot");
      txn(0, 1, reply(24'h123456), 32'h0BAD_BEEF);

      txn(0, 1, reply(24'd0), 32'h7777_7777);
      check_pend("R6 slot stays empty");

      txn(0, 1, notify(5'd1, 8'd2), 32'h0);
      txn(0, 1, notify(5'd31, 8'd5), 32'h0);
      txn(0, 1, notify(5'd3, 8'h41), 32'h0);
      txn(0, 1, notify(5'd0, 8'd2), 32'h0);

      txn(1, 0, 32'h0, 32'h0);
      txn(0, 0, 32'h0, 32'h0);

      // R11 event during running sequence is ignored
      expect_txn(1, 1, notify(5'd2, 8'd5), 32'h0);
      @(posedge clk); #1;
      in_primary = notify(5'd2, 8'd5); in_busy = 1'b1; out_done = 1'b1; irq_ev = 1'b1;
      @(posedge clk); #1;
      irq_ev = 1'b0;
      @(posedge clk); #1;
      irq_ev = 1'b1;
      @(posedge clk); #1;
      irq_ev = 1'b0;
      repeat (8) @(posedge clk);
      #1;
      in_busy = 1'b0; out_done = 1'b0;
      repeat (4) @(posedge clk);

      #1;
      check("R7 all expected outputs seen", {17'd0, 32'(exp_q.size())}, 49'd0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule